// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked system and an asynchronous static RAM of one million 32-bit words. A single-word request is taken through a valid/ready handshake. The block then produces the memory's chip-select, output-enable and write-enable strobes, all active low, and holds address and write data steady for as many clock cycles as each analog timing limit needs. The data bus is split into an outbound word, an inbound word and a drive-enable for an external tri-state buffer. A read returns its word with a one-cycle valid pulse.

Every interval is a whole number of clock cycles. It is the ceiling of the nanosecond limit divided by the clock-period parameter, and never less than one. At the default 10 ns clock and the 20 ns speed grade, the counts are as follows:
- read access: 2 cycles plus 1 capture cycle
- write setup: 1 cycle
- write-enable pulse: 2 cycles
- write hold: 1 cycle
- turnaround: 1 cycle

A different speed grade only needs a different set of nanosecond parameters.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip select, write enable and output enable are high, the bus driver is off, read-valid is low, and ready is high.
- R2: Ready is high only when no access is in progress. A request is accepted only on a clock edge where request and ready are both high. A request held high during an access starts nothing and changes no strobe.
- R3: After a read is accepted, chip select and output enable are low and the address is driven for 3 cycles (2 access cycles and 1 capture cycle). Write enable stays high throughout.
- R4: The inbound word is sampled on the edge that ends the capture cycle. Read-valid is then high for exactly one cycle, in the 4th cycle after acceptance, and carries that word.
- R5: After a write is accepted, chip select is low, write enable is high and output enable is high for 1 setup cycle, with address and data already driven, before write enable falls.
- R6: Write enable is low for 2 cycles while chip select stays low. Output enable stays high for the whole write.
- R7: Chip select and write enable rise together to end the write. Address and write data stay driven for 1 further hold cycle.
- R8: Every read and every write ends with 1 turnaround cycle in which all strobes are high and the driver is off. Ready returns in the following cycle.
- R9: The data bus is never driven while output enable is low.
- R10: Words written to distinct addresses with distinct patterns read back unchanged. This includes the all-ones and all-zeros words and the highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Idle, a request is accepted |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 32 | Captured read word |
| mem_addr | output | 20 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 32 | Outbound data |
| mem_dq_in | input | 32 | Inbound data |
| mem_dq_oe | output | 1 | External bus driver enable |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- write enable stays inside the chip-select window and never falls without a setup cycle before it
- the address does not move while chip select is low
- the driver is never on with output enable low
- read-valid is a single pulse
- ready only appears with all strobes idle

The per-state cycle counts, the capture instant, the ignoring of requests while busy, and data integrity through a behavioural memory are shown only by the bench's directed scenarios.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_CAP   = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5,
    ST_TURN     = 3'd6
  } asram_state_e;

  // ceiling of ns / period, never below one cycle
  function automatic int ns2cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int N_RD  = 2,
  parameter int N_AS  = 1,
  parameter int N_WP  = 2,
  parameter int N_WH  = 1,
  parameter int N_TA  = 1,
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic cap_en,
  output logic rd_valid,
  output logic mem_cs_n,
  output logic mem_oe_n,
  output logic mem_we_n,
  output logic mem_dq_oe
);

  localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_AS = CNT_W'(N_AS - 1);
  localparam logic [CNT_W-1:0] LD_WP = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LD_WH = CNT_W'(N_WH - 1);
  localparam logic [CNT_W-1:0] LD_TA = CNT_W'(N_TA - 1);

  asram_state_e     st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cs_d, oe_d, we_d, dqoe_d, rdv_d;
  logic             last;

  assign last      = (cnt_q == '0);
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cap_en    = (st_q == ST_RD_CAP);

  // next-state and interval counter
  always_comb begin
    st_d  = st_q;
    cnt_d = last ? cnt_q : cnt_q - 1'b1;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        if (req_write) begin st_d = ST_WR_SETUP; cnt_d = LD_AS; end
        else           begin st_d = ST_RD_ACC;   cnt_d = LD_RD; end
      end
      ST_RD_ACC:   if (last) st_d = ST_RD_CAP;
      ST_RD_CAP:   begin st_d = ST_TURN; cnt_d = LD_TA; end
      ST_WR_SETUP: if (last) begin st_d = ST_WR_PULSE; cnt_d = LD_WP; end
      ST_WR_PULSE: if (last) begin st_d = ST_WR_HOLD;  cnt_d = LD_WH; end
      ST_WR_HOLD:  if (last) begin st_d = ST_TURN;     cnt_d = LD_TA; end
      ST_TURN:     if (last) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  // strobes decoded from the next state, then registered
  always_comb begin
    cs_d   = !(st_d inside {ST_RD_ACC, ST_RD_CAP, ST_WR_SETUP, ST_WR_PULSE});
    oe_d   = !(st_d inside {ST_RD_ACC, ST_RD_CAP});
    we_d   = !(st_d == ST_WR_PULSE);
    dqoe_d =  (st_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
    rdv_d  =  cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      mem_cs_n  <= cs_d;
      mem_oe_n  <= oe_d;
      mem_we_n  <= we_d;
      mem_dq_oe <= dqoe_d;
      rd_valid  <= rdv_d;
    end
  end

  assert_rd_we_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);
  assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_setup_before_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_cs_n && $past(!mem_cs_n) && $past(mem_dq_oe)));
  assert_we_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));
  assert_hold_after_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_cs_n && mem_dq_oe));
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));
  assert_no_drive_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (cap_en) rd_data <= mem_dq_in;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int CLK_NS  = 10,
  parameter int T_RC    = 20,
  parameter int T_AA    = 20,
  parameter int T_DOE   = 12,
  parameter int T_HZOE  = 10,
  parameter int T_WC    = 20,
  parameter int T_PWE   = 15,
  parameter int T_SCS   = 17,
  parameter int T_AW    = 17,
  parameter int T_SA    = 2,
  parameter int T_SD    = 12,
  parameter int T_HA    = 3,
  parameter int T_HD    = 2,
  parameter int T_LZWE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  // access plus capture cycle must cover the read cycle time
  localparam int N_RD = imax(imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_DOE, CLK_NS)),
                             ns2cyc(T_RC, CLK_NS) - 1);
  localparam int N_AS = ns2cyc(T_SA, CLK_NS);
  localparam int N_WP = imax(imax(ns2cyc(T_PWE, CLK_NS), ns2cyc(T_SD, CLK_NS)),
                             imax(ns2cyc(T_SCS, CLK_NS), ns2cyc(T_AW, CLK_NS) - N_AS));
  localparam int N_WH = imax(imax(ns2cyc(T_HA, CLK_NS), ns2cyc(T_HD, CLK_NS)),
                             ns2cyc(T_WC, CLK_NS) - N_AS - N_WP);
  localparam int N_TA = imax(ns2cyc(T_HZOE, CLK_NS), ns2cyc(T_LZWE, CLK_NS));
  localparam int N_MX = imax(imax(N_RD, N_AS), imax(imax(N_WP, N_WH), N_TA));
  localparam int CNT_W = (N_MX < 2) ? 1 : $clog2(N_MX);

  logic accept, cap_en;

  asram_seq #(
    .N_RD(N_RD), .N_AS(N_AS), .N_WP(N_WP), .N_WH(N_WH), .N_TA(N_TA), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .cap_en(cap_en), .rd_valid(rd_valid),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_oe(mem_dq_oe)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cap_en(cap_en),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rd_data(rd_data)
  );

  assert_addr_stable_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  assert_data_stable_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rd_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [31:0] rd_data, mem_dq_out, mem_dq_in;
  logic [19:0] mem_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int n_cyc   = 0;

  logic [31:0] mem  [256];
  logic [31:0] shad [256];
  logic        wr_act;

  always #(CLK_P/2) clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // behavioural memory: write at the end of the cs/we overlap
  assign wr_act    = !mem_cs_n && !mem_we_n;
  assign mem_dq_in = (!mem_cs_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 32'hBAD0_BAD0;
  always @(negedge wr_act) mem[mem_addr[7:0]] = mem_dq_out;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // R9 monitored on every falling edge
  always @(negedge clk) if (rst_n && mem_dq_oe && !mem_oe_n) begin
    n_fail++;
    $display("FAIL R9: actual dq_oe=1 oe_n=0 expected no drive");
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // strobes packed {cs_n, oe_n, we_n, dq_oe}
  function automatic logic [3:0] strb();
    return {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {28'd0, strb()}, 32'hE);
    chk("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {28'd0, strb()}, 32'hE);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
  endtask

  // busy_req: keep a write request high during the read (R2)
  task automatic t_read(input logic [19:0] a, input bit busy_req);
    logic [31:0] exp;
    exp = shad[a[7:0]];
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    if (busy_req) begin
      req_write = 1'b1; req_addr = a ^ 20'h00055; req_wdata = 32'h0BAD_F00D;
    end else req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R3 read strobes", {28'd0, strb()}, 32'h2);
      chk("R3 read address", {12'd0, mem_addr}, {12'd0, a});
      chk("R2 ready low during read", {31'd0, req_ready}, 32'd0);
      chk("R4 no early valid", {31'd0, rd_valid}, 32'd0);
      if (k == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    chk("R8 turnaround strobes after read", {28'd0, strb()}, 32'hE);
    chk("R4 read valid", {31'd0, rd_valid}, 32'd1);
    chk("R4 read data", rd_data, exp);
    chk("R8 ready low in turnaround", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R4 valid single pulse", {31'd0, rd_valid}, 32'd0);
    chk("R8 ready after turnaround", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_write(input logic [19:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 setup strobes", {28'd0, strb()}, 32'h7);
    chk("R5 setup address", {12'd0, mem_addr}, {12'd0, a});
    chk("R5 setup data", mem_dq_out, d);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R6 pulse strobes", {28'd0, strb()}, 32'h5);
      @(negedge clk);
    end
    chk("R7 hold strobes", {28'd0, strb()}, 32'hF);
    chk("R7 hold address", {12'd0, mem_addr}, {12'd0, a});
    chk("R7 hold data", mem_dq_out, d);
    @(negedge clk);
    chk("R8 turnaround strobes after write", {28'd0, strb()}, 32'hE);
    chk("R8 ready low in turnaround", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R8 ready after write", {31'd0, req_ready}, 32'd1);
    shad[a[7:0]] = d;
  endtask

  task automatic t_readback();
    t_write(20'hFFFFF, 32'hFFFF_FFFF);
    t_write(20'h00001, 32'h0000_0000);
    t_write(20'h00002, 32'hA5A5_5A5A);
    t_write(20'h00003, 32'h1234_5678);
    t_read(20'hFFFFF, 1'b0);
    t_read(20'h00001, 1'b0);
    t_read(20'h00002, 1'b0);
    t_read(20'h00003, 1'b0);
    chk("R10 memory content", mem[8'h02], 32'hA5A5_5A5A);
  endtask

  task automatic t_busy_ignore();
    t_read(20'h00010, 1'b1);
    chk("R2 ignored write left memory", mem[8'h45], shad[8'h45]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 32'hC000_0000 ^ (i * 32'h0101_0101);
      shad[i] = 32'hC000_0000 ^ (i * 32'h0101_0101);
    end
    t_reset();
    t_read(20'h00020, 1'b0);
    t_write(20'h00030, 32'hDEAD_BEEF);
    t_read(20'h00030, 1'b0);
    t_readback();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule